// File: doc/BRIEF.md
# Greedy compacted-syndrome error locator

This block takes the mismatch pattern of a compacted test signature and works back to the uncompacted scan cells that most likely caused it. Alongside the mismatch pattern it receives a mask of signature bits that unknown values reached. Those bits carry no information and are dropped from every step. The code matrix, which records which scan cells feed which signature bits, arrives as a flat column-per-input vector. It comes from a regenerating copy of the compactor's code generator, or from a small preloaded store, and is held steady while the block works.

Decoding is a greedy vote. Each candidate input earns +1 for every errored usable output it feeds and -1 for every clean usable output it feeds. The best candidate is taken, and its column is XORed out of the residual syndrome. The loop ends when the residual is clean or when a fixed number of picks has been spent. Before any voting, a response whose usable outputs are about half or more in error is rejected as too noisy to decode. Several repeated runs of the same test, each compacted with its own random code, are decoded together by laying their signatures side by side as one wider syndrome.

Top module: `lc_err_locator`

## Requirements
- R1: A one-cycle `start` while idle captures `syndrome` and `unk_mask` and raises `busy`. A `start` seen while `busy` is high is ignored and does not change the result.
- R2: An output with its `unk_mask` bit at 1 is unusable. Its syndrome bit has no effect on scoring, on the error count or on the zero test.
- R3: If no usable output is in error, the run ends with `found`=1, `loc_count`=0 and `loc_hits`=0.
- R4: If E usable outputs are in error out of U usable outputs, E>0 and 2*E >= U, the run ends with `undiag`=1 and no locations. At most one of `found`, `give_up` and `undiag` is ever 1.
- R5: In each pass, each unpicked input scores +1 for every usable output it feeds whose residual bit is 1. It scores -1 for every usable output it feeds whose residual bit is 0. Column i of `code_cols` is bits [i*N_OUT +: N_OUT], and bit o of it set means input i feeds output o.
- R6: The unpicked input with the highest score is picked. On equal scores, the lowest input index wins.
- R7: An input that has been picked once is never picked again in the same run.
- R8: After a pick, the residual becomes residual XOR (picked column AND usable). When the residual reaches zero, the run ends with `found`=1.
- R9: If MAX_PICKS picks leave a nonzero residual, the run ends with `give_up`=1.
- R10: Output index o = r*RUN_BITS + b is bit b of run r. All runs are decoded as one syndrome, so a fully masked run does not prevent decoding from the others.
- R11: `done` pulses for one cycle when `busy` falls. Pick j sits at `loc_list[j*IDX_W +: IDX_W]`, and `loc_hits` has bit i set for every picked i. All results hold until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a decode |
| syndrome | input | N_OUT | Mismatched signature bits, all runs concatenated |
| unk_mask | input | N_OUT | 1 marks an output touched by unknowns |
| code_cols | input | N_IN*N_OUT | Code matrix, one N_OUT-bit column per input |
| busy | output | 1 | Decode in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| found | output | 1 | Residual reached zero |
| give_up | output | 1 | Pick budget spent without success |
| undiag | output | 1 | Too many errors to attempt decoding |
| loc_count | output | $clog2(MAX_PICKS+1) | Number of picks made |
| loc_list | output | MAX_PICKS*IDX_W | Picked input indices in pick order |
| loc_hits | output | N_IN | One bit per picked input |

## Verification
The rule that excludes an input once it is picked is the hardest behaviour to reach. With random codes, a picked input almost never wins a second vote. The stimulus therefore uses a hand-built matrix. One narrow column is picked first, but after the XOR it still scores higher than every remaining candidate, whose wide columns cover many clean outputs. Reaching the tie and partial-masking corners likewise relies on crafted matrices with duplicated columns and on masking one whole run. Every run's outcome is compared with a reference decode that the scoreboard computes.

// File: rtl/lc_pkg.sv
package lc_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_CHECK = 2'd1,
    S_SCORE = 2'd2,
    S_PICK  = 2'd3
  } lc_state_e;
endpackage

// File: rtl/lc_score_bank.sv
module lc_score_bank #(
  parameter int N_IN  = 16,
  parameter int SW    = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               en,
  input  logic [N_IN-1:0]    feeds,
  input  logic [N_IN-1:0]    excl,
  input  logic               err_bit,
  input  logic               use_bit,
  output logic [N_IN*SW-1:0] scores
);
  localparam logic [SW-1:0] PLUS  = SW'(1);
  localparam logic [SW-1:0] MINUS = {SW{1'b1}};

  for (genvar i = 0; i < N_IN; i++) begin : g_acc
    logic [SW-1:0] acc_q, acc_d;
    logic          acc_en;

    always_comb begin
      acc_en = clr | (en & use_bit & feeds[i] & ~excl[i]);
      acc_d  = clr ? '0 : acc_q + (err_bit ? PLUS : MINUS);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc_q <= '0;
      else if (acc_en) acc_q <= acc_d;
    end

    assign scores[i*SW +: SW] = acc_q;
  end

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (scores == '0));
endmodule

// File: rtl/lc_pick_max.sv
module lc_pick_max #(
  parameter int N_IN  = 16,
  parameter int SW    = 6,
  parameter int IDX_W = 4
) (
  input  logic [N_IN*SW-1:0] scores,
  input  logic [N_IN-1:0]    excl,
  output logic [IDX_W-1:0]   win_idx,
  output logic               win_valid
);
  logic signed [SW-1:0] best;
  logic signed [SW-1:0] cand;

  always_comb begin
    best      = '0;
    cand      = '0;
    win_idx   = '0;
    win_valid = 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      cand = scores[i*SW +: SW];
      if (!excl[i] && (!win_valid || cand > best)) begin
        best      = cand;
        win_idx   = IDX_W'(i);
        win_valid = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lc_err_locator.sv
module lc_err_locator
  import lc_pkg::*;
#(
  parameter int N_IN      = 16,
  parameter int RUN_BITS  = 8,
  parameter int N_RUNS    = 2,
  parameter int MAX_PICKS = 4,
  localparam int N_OUT    = RUN_BITS * N_RUNS,
  localparam int IDX_W    = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int CW       = $clog2(MAX_PICKS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [N_OUT-1:0]         syndrome,
  input  logic [N_OUT-1:0]         unk_mask,
  input  logic [N_IN*N_OUT-1:0]    code_cols,
  output logic                     busy,
  output logic                     done,
  output logic                     found,
  output logic                     give_up,
  output logic                     undiag,
  output logic [CW-1:0]            loc_count,
  output logic [MAX_PICKS*IDX_W-1:0] loc_list,
  output logic [N_IN-1:0]          loc_hits
);
  localparam int OW  = (N_OUT > 1) ? $clog2(N_OUT) : 1;
  localparam int OCW = $clog2(N_OUT + 1);
  localparam int SW  = OCW + 1;

  lc_state_e state_q, state_d;
  logic [N_OUT-1:0] resid_q, resid_d, use_q, use_d;
  logic [OW-1:0]    idx_q, idx_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [MAX_PICKS*IDX_W-1:0] list_q, list_d;
  logic [N_IN-1:0]  hit_q, hit_d;
  logic found_q, found_d, gu_q, gu_d, und_q, und_d, done_q, done_d;

  logic [N_IN-1:0]    row;
  logic [N_IN*SW-1:0] scores;
  logic               sc_clr, sc_en;
  logic [IDX_W-1:0]   win_idx;
  logic               win_valid;
  logic [N_OUT-1:0]   win_col, resid_nx;
  logic [OCW-1:0]     err_n, use_n;
  logic [OCW:0]       err2, use2;

  // which inputs feed the output under scan this cycle
  always_comb begin
    for (int i = 0; i < N_IN; i++) row[i] = code_cols[i*N_OUT + int'(idx_q)];
  end

  lc_score_bank #(.N_IN(N_IN), .SW(SW)) u_bank (
    .clk(clk), .rst_n(rst_n), .clr(sc_clr), .en(sc_en),
    .feeds(row), .excl(hit_q),
    .err_bit(resid_q[idx_q]), .use_bit(use_q[idx_q]),
    .scores(scores)
  );

  lc_pick_max #(.N_IN(N_IN), .SW(SW), .IDX_W(IDX_W)) u_pick (
    .scores(scores), .excl(hit_q), .win_idx(win_idx), .win_valid(win_valid)
  );

  assign win_col  = code_cols[int'(win_idx)*N_OUT +: N_OUT];
  assign resid_nx = resid_q ^ (win_col & use_q);
  assign err_n    = OCW'($countones(resid_q));
  assign use_n    = OCW'($countones(use_q));
  assign err2     = {err_n, 1'b0};
  assign use2     = {1'b0, use_n};

  always_comb begin
    state_d = state_q;
    resid_d = resid_q;
    use_d   = use_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    list_d  = list_q;
    hit_d   = hit_q;
    found_d = found_q;
    gu_d    = gu_q;
    und_d   = und_q;
    done_d  = 1'b0;
    sc_clr  = 1'b0;
    sc_en   = 1'b0;
    unique case (state_q)
      S_IDLE: if (start) begin
        resid_d = syndrome & ~unk_mask;
        use_d   = ~unk_mask;
        cnt_d   = '0;
        list_d  = '0;
        hit_d   = '0;
        found_d = 1'b0;
        gu_d    = 1'b0;
        und_d   = 1'b0;
        state_d = S_CHECK;
      end
      S_CHECK: begin
        if (resid_q == '0) begin
          found_d = 1'b1;
          done_d  = 1'b1;
          state_d = S_IDLE;
        end else if (err2 >= use2) begin
          und_d   = 1'b1;
          done_d  = 1'b1;
          state_d = S_IDLE;
        end else begin
          sc_clr  = 1'b1;
          idx_d   = '0;
          state_d = S_SCORE;
        end
      end
      S_SCORE: begin
        sc_en = 1'b1;
        idx_d = idx_q + 1'b1;
        if (int'(idx_q) == N_OUT - 1) state_d = S_PICK;
      end
      S_PICK: begin
        if (!win_valid) begin
          gu_d    = 1'b1;
          done_d  = 1'b1;
          state_d = S_IDLE;
        end else begin
          for (int j = 0; j < MAX_PICKS; j++)
            if (cnt_q == CW'(j)) list_d[j*IDX_W +: IDX_W] = win_idx;
          hit_d[win_idx] = 1'b1;
          cnt_d   = cnt_q + 1'b1;
          resid_d = resid_nx;
          if (resid_nx == '0) begin
            found_d = 1'b1;
            done_d  = 1'b1;
            state_d = S_IDLE;
          end else if (cnt_q == CW'(MAX_PICKS - 1)) begin
            gu_d    = 1'b1;
            done_d  = 1'b1;
            state_d = S_IDLE;
          end else begin
            sc_clr  = 1'b1;
            idx_d   = '0;
            state_d = S_SCORE;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      resid_q <= '0;
      use_q   <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      list_q  <= '0;
      hit_q   <= '0;
      found_q <= 1'b0;
      gu_q    <= 1'b0;
      und_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      resid_q <= resid_d;
      use_q   <= use_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      list_q  <= list_d;
      hit_q   <= hit_d;
      found_q <= found_d;
      gu_q    <= gu_d;
      und_q   <= und_d;
      done_q  <= done_d;
    end
  end

  assign busy      = (state_q != S_IDLE);
  assign done      = done_q;
  assign found     = found_q;
  assign give_up   = gu_q;
  assign undiag    = und_q;
  assign loc_count = cnt_q;
  assign loc_list  = list_q;
  assign loc_hits  = hit_q;

  assert_masked_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (resid_q & ~use_q) == '0);
  assert_one_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({found_q, gu_q, und_q}));
  assert_fresh_pick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PICK && win_valid) |-> !hit_q[win_idx]);
  assert_hits_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hit_q) == int'(cnt_q));
  assert_found_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    found_q |-> (resid_q == '0));
  assert_pick_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= MAX_PICKS);
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state_q == S_IDLE && $past(state_q) != S_IDLE));
endmodule

// File: tb/lc_err_locator_bench.sv
module lc_err_locator_bench;
  localparam int N_IN = 16, RUN_BITS = 8, N_RUNS = 2, MAX_PICKS = 4;
  localparam int N_OUT = RUN_BITS * N_RUNS;
  localparam int IDX_W = 4, CW = 3;

  typedef struct packed {
    logic f, g, u;
    logic [CW-1:0] cnt;
    logic [MAX_PICKS*IDX_W-1:0] list;
    logic [N_IN-1:0] hit;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [N_OUT-1:0] syndrome = '0, unk_mask = '0;
  logic [N_IN*N_OUT-1:0] code = '0;
  logic busy, done, found, give_up, undiag;
  logic [CW-1:0] loc_count;
  logic [MAX_PICKS*IDX_W-1:0] loc_list;
  logic [N_IN-1:0] loc_hits;

  int checks = 0, fails = 0;
  exp_t exp_q[$];
  exp_t last_exp;
  string tag_q[$];
  logic [31:0] lfsr = 32'hACE1_2468;

  always #5 clk = ~clk;

  lc_err_locator #(.N_IN(N_IN), .RUN_BITS(RUN_BITS), .N_RUNS(N_RUNS), .MAX_PICKS(MAX_PICKS))
  u_lc_err_locator (
    .clk(clk), .rst_n(rst_n), .start(start), .syndrome(syndrome), .unk_mask(unk_mask),
    .code_cols(code), .busy(busy), .done(done), .found(found), .give_up(give_up),
    .undiag(undiag), .loc_count(loc_count), .loc_list(loc_list), .loc_hits(loc_hits)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [N_OUT-1:0] col(input int i);
    return code[i*N_OUT +: N_OUT];
  endfunction

  function automatic logic rbit();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr[0];
  endfunction

  task automatic random_code();
    for (int k = 0; k < N_IN*N_OUT; k++) code[k] = rbit() & rbit();
  endtask

  // reference greedy decode written from the requirements
  function automatic exp_t model(input logic [N_OUT-1:0] syn, input logic [N_OUT-1:0] msk);
    exp_t e;
    logic [N_OUT-1:0] res, usb;
    int best, bi, sc;
    e = '0;
    usb = ~msk;
    res = syn & usb;
    if (res == '0) begin e.f = 1'b1; return e; end
    if (2*$countones(res) >= $countones(usb)) begin e.u = 1'b1; return e; end
    for (int p = 0; p < MAX_PICKS; p++) begin
      bi = -1; best = 0;
      for (int i = 0; i < N_IN; i++) begin
        if (e.hit[i]) continue;
        sc = 0;
        for (int o = 0; o < N_OUT; o++)
          if (usb[o] && col(i)[o]) sc += res[o] ? 1 : -1;
        if (bi < 0 || sc > best) begin best = sc; bi = i; end
      end
      if (bi < 0) begin e.g = 1'b1; return e; end
      e.list[p*IDX_W +: IDX_W] = IDX_W'(bi);
      e.hit[bi] = 1'b1;
      e.cnt = CW'(p + 1);
      res = res ^ (col(bi) & usb);
      if (res == '0) begin e.f = 1'b1; return e; end
    end
    e.g = 1'b1;
    return e;
  endfunction

  // driver: push expectation, start, optionally poke start while busy
  task automatic run_case(input string tag, input logic [N_OUT-1:0] syn,
                          input logic [N_OUT-1:0] msk, input bit poke);
    @(negedge clk);
    syndrome = syn;
    unk_mask = msk;
    exp_q.push_back(model(syn, msk));
    tag_q.push_back(tag);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      syndrome = ~syn;
      unk_mask = '0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (exp_q.size() == 0);
    repeat (3) @(negedge clk);
    check({tag, " R11 hold"}, {found, give_up, undiag, loc_count, loc_list, loc_hits},
          {last_exp.f, last_exp.g, last_exp.u, last_exp.cnt, last_exp.list, last_exp.hit});
  endtask

  // monitor: compare on each done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R11 unexpected done actual=1 expected=0");
      end else begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        last_exp = e;
        check({t, " outcome"}, {found, give_up, undiag}, {e.f, e.g, e.u});
        check({t, " count"}, loc_count, e.cnt);
        check({t, " list"}, loc_list, e.list);
        check({t, " hits"}, loc_hits, e.hit);
        check({t, " R11 idle"}, busy, 1'b0);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset state", {busy, done, found, give_up, undiag, loc_count, loc_hits}, '0);

    random_code();
    run_case("R3 zero syndrome", '0, '0, 1'b0);
    run_case("R5 R6 R8 single error", col(5), '0, 1'b0);
    run_case("R1 start ignored while busy", col(12), '0, 1'b1);
    run_case("R5 R8 two errors", col(2) ^ col(9), '0, 1'b0);
    run_case("R2 masked bits ignored", col(7) | 16'h0300, 16'h0300, 1'b0);
    check("R2 masked result equals unmasked view", loc_hits,
          model(col(7) & ~16'h0300, 16'h0300).hit);
    run_case("R4 heavy errors", 16'hFFFF, '0, 1'b0);
    run_case("R3 all masked", 16'hFFFF, 16'hFFFF, 1'b0);
    run_case("R10 run0 masked", col(11), 16'h00FF, 1'b0);
    run_case("R10 error in run1 only", col(4) & 16'hFF00, '0, 1'b0);

    // tie: identical columns at 3 and 5, lowest index wins
    code = '0;
    code[3*N_OUT +: N_OUT] = 16'h0013;
    code[5*N_OUT +: N_OUT] = 16'h0013;
    run_case("R6 tie lowest index", 16'h0013, '0, 1'b0);
    check("R6 tie picks input 3", loc_list[IDX_W-1:0], 4'd3);

    // exclusion: input 0 keeps the top score after its pick
    for (int i = 0; i < N_IN; i++) code[i*N_OUT +: N_OUT] = (i == 0) ? 16'h000F : 16'hFFE0;
    run_case("R7 R9 excluded repick", 16'h0017, '0, 1'b0);
    check("R7 second pick not input 0", loc_list[2*IDX_W-1:IDX_W], 4'd1);
    check("R9 gave up at budget", {give_up, loc_count}, {1'b1, 3'd4});

    finish_run();
  end
endmodule